// File: doc/BRIEF.md
# Dual-Load Write-Through Level-1 Data Cache

This block is a first-level data cache of 8 KB, built as 256 direct-mapped lines of 32 bytes. Both index and tag come from the physical address. Two load ports look up the cache in parallel and are answered combinationally in the same cycle, so two loads can finish together. One store port passes every store straight through to a downstream write queue. A store that hits also patches the cached copy. A store that misses leaves the cache unchanged, because only loads allocate lines.

A load that misses does not finish. The requester keeps its request and address steady. The refill controller latches the missing line and asks the next level for it through a request/ready handshake. It then takes four 64-bit beats and installs the line when the last beat arrives. The waiting load hits on the next cycle. Only one refill is outstanding at a time. When both ports miss, port 0 is served first. A shared line is fetched once and answers both ports.

Load and store addresses are doubleword addresses, meaning byte address bits [39:3]. On a load port, bits [1:0] select the 64-bit word within the line, bits [9:2] are the line index (byte address bits [12:5]), and bits [36:10] are the tag. The store port uses the same layout.

Top module: `l1d_dual_cache`

## Requirements
- R1: During reset and after it, every line is invalid. No load completes until its line has been filled. With no load misses, `fill_req_vld` stays low.
- R2: A load miss raises `fill_req_vld` on the following cycle with `fill_req_line` equal to the load's line address (port bits [36:2]). Both stay unchanged until `fill_req_rdy` is seen high at a clock edge.
- R3: After the request is accepted, the next four cycles with `fill_vld` high carry beats 0 to 3. Beat k holds word k of the line. The tag and valid bit are written on beat 3. From the next cycle a load to that line hits, and `ld_data` returns the word chosen by address bits [1:0].
- R4: When both load ports hit in the same cycle, both `ld_done` bits are high in that cycle, and each port returns its own word.
- R5: When both ports miss on different lines, port 0's line is requested first. Port 1's line is requested only after port 0's line has been installed.
- R6: When both ports miss on the same line, one request is made. Both ports complete in the cycle after the install, and no further request follows.
- R7: A store is accepted when `st_req` and `wq_rdy` are both high, and `st_rdy` mirrors `wq_rdy`. In that same cycle the write queue receives the same address, data and byte enables. A store that is not accepted changes nothing.
- R8: An accepted store that hits changes only the bytes of the addressed word whose `st_be` bit is set (bit i covers data bits [8i+7:8i]). Loads see the change from the next cycle.
- R9: An accepted store that misses is still written through. It raises no refill request, and the line stays a miss.
- R10: A load that hits the same word as a store hit in the same cycle returns the data from before the store.
- R11: A cycle with `flush` high clears every valid bit, so all later loads miss until their lines are refilled.
- R12: A refill evicts the line held at its index. That old line keeps hitting until the refill request is accepted, and it misses from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every line |
| ld_req | input | 2 | Per-port load request, held until done |
| ld_addr | input | 2x37 | Per-port doubleword address |
| ld_done | output | 2 | Per-port load hit, data valid this cycle |
| ld_data | output | 2x64 | Per-port load word |
| st_req | input | 1 | Store request |
| st_addr | input | 37 | Store doubleword address |
| st_wdata | input | 64 | Store data |
| st_be | input | 8 | Store byte enables |
| st_rdy | output | 1 | Store accepted when high with st_req |
| wq_vld | output | 1 | Write-queue entry valid |
| wq_addr | output | 37 | Write-queue doubleword address |
| wq_data | output | 64 | Write-queue data |
| wq_be | output | 8 | Write-queue byte enables |
| wq_rdy | input | 1 | Write queue can take an entry |
| fill_req_vld | output | 1 | Refill request valid |
| fill_req_line | output | 35 | Refill line address |
| fill_req_rdy | input | 1 | Next level accepts the refill request |
| fill_vld | input | 1 | Refill beat valid |
| fill_data | input | 64 | Refill beat data |

## Verification
The hardest case is a double miss. The two load ports miss together, and port 1's miss must survive port 0's whole refill before it is requested. The stimulus raises both loads in one cycle and keeps both held while the bench acts as the next level. It serves port 0's line one beat at a time and checks that port 1's line is only requested after port 0 completes. The eviction window is reached in a similar way. The bench stalls the request handshake and probes the victim line from the other port while the request is still pending, then probes it again after the install.

// File: rtl/l1d_pkg.sv
package l1d_pkg;

  typedef enum logic [1:0] {
    RF_IDLE = 2'd0,
    RF_REQ  = 2'd1,
    RF_FILL = 2'd2
  } refill_state_e;

endpackage

// File: rtl/l1d_tag_store.sv
module l1d_tag_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 27,
  parameter int NRD   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
  input  logic [NRD-1:0][TAG_W-1:0]   rd_tag,
  output logic [NRD-1:0]              rd_hit,
  input  logic                        inv_en,
  input  logic                        inst_en,
  input  logic [IDX_W-1:0]            line_idx,
  input  logic [TAG_W-1:0]            line_tag,
  input  logic                        fill_busy
);

  localparam int NUM_LINES = 1 << IDX_W;

  logic [NUM_LINES-1:0] valid_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (flush) begin
        valid_q <= '0;
      end else if (inv_en) begin
        valid_q[line_idx] <= 1'b0;
      end
      if (inst_en) begin
        valid_q[line_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (inst_en) begin
      tag_q[line_idx] <= line_tag;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_hit[r] = valid_q[rd_idx[r]] && (tag_q[rd_idx[r]] == rd_tag[r]);
  end

  // R11: a flush empties the whole valid array unless a line is being installed
  a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !inst_en) |=> (valid_q == '0));

  // R12: while beats stream in, the target line must read as invalid
  a_r12_victim_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !valid_q[line_idx]);

endmodule

// File: rtl/l1d_line_data.sv
module l1d_line_data #(
  parameter int IDX_W  = 8,
  parameter int WSEL_W = 2,
  parameter int WORD_W = 64,
  parameter int NRD    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
  input  logic [NRD-1:0][WSEL_W-1:0]  rd_sel,
  output logic [NRD-1:0][WORD_W-1:0]  rd_data,
  input  logic                        fw_en,
  input  logic [IDX_W-1:0]            fw_idx,
  input  logic [WSEL_W-1:0]           fw_sel,
  input  logic [WORD_W-1:0]           fw_data,
  input  logic                        sw_en,
  input  logic [IDX_W-1:0]            sw_idx,
  input  logic [WSEL_W-1:0]           sw_sel,
  input  logic [WORD_W-1:0]           sw_data,
  input  logic [WORD_W/8-1:0]         sw_be
);

  localparam int NBYTES  = WORD_W / 8;
  localparam int ENTRIES = (1 << IDX_W) << WSEL_W;

  logic [WORD_W-1:0] mem_q [ENTRIES];

  function automatic logic [WORD_W-1:0] merge_bytes(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w,
    input logic [NBYTES-1:0] be
  );
    logic [WORD_W-1:0] res;
    res = old_w;
    for (int b = 0; b < NBYTES; b++) begin
      if (be[b]) res[8*b +: 8] = new_w[8*b +: 8];
    end
    return res;
  endfunction

  always_ff @(posedge clk) begin
    if (fw_en) begin
      mem_q[{fw_idx, fw_sel}] <= fw_data;
    end
    if (sw_en) begin
      mem_q[{sw_idx, sw_sel}] <= merge_bytes(mem_q[{sw_idx, sw_sel}], sw_data, sw_be);
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r] = mem_q[{rd_idx[r], rd_sel[r]}];
  end

  // R9: a store patch never lands in the line that is being refilled
  a_r9_store_not_into_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && fw_en) |-> (sw_idx != fw_idx));

endmodule

// File: rtl/l1d_refill_fsm.sv
module l1d_refill_fsm
  import l1d_pkg::*;
#(
  parameter int LINE_W = 35,
  parameter int IDX_W  = 8,
  parameter int WSEL_W = 2,
  parameter int NPORT  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             miss_vec,
  input  logic [NPORT-1:0][LINE_W-1:0] miss_line,
  input  logic                         fill_req_rdy,
  input  logic                         fill_vld,
  output logic                         fill_req_vld,
  output logic [LINE_W-1:0]            fill_req_line,
  output logic [IDX_W-1:0]             line_idx,
  output logic [LINE_W-IDX_W-1:0]      line_tag,
  output logic                         inv_en,
  output logic                         fw_en,
  output logic [WSEL_W-1:0]            fw_sel,
  output logic                         inst_en,
  output logic                         busy
);

  localparam int PSEL_W = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam logic [WSEL_W-1:0] LAST_BEAT = '1;

  refill_state_e     st_q;
  logic [LINE_W-1:0] line_q;
  logic [WSEL_W-1:0] beat_q;
  logic [PSEL_W-1:0] pick;
  logic              any_miss;

  // lowest-numbered missing port wins
  always_comb begin
    pick = '0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (miss_vec[p]) pick = PSEL_W'(p);
    end
  end
  assign any_miss = |miss_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= RF_IDLE;
      line_q <= '0;
      beat_q <= '0;
    end else begin
      case (st_q)
        RF_IDLE: begin
          if (any_miss) begin
            line_q <= miss_line[pick];
            st_q   <= RF_REQ;
          end
        end
        RF_REQ: begin
          if (fill_req_rdy) begin
            beat_q <= '0;
            st_q   <= RF_FILL;
          end
        end
        RF_FILL: begin
          if (fill_vld) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) st_q <= RF_IDLE;
          end
        end
        default: st_q <= RF_IDLE;
      endcase
    end
  end

  assign fill_req_vld  = (st_q == RF_REQ);
  assign fill_req_line = line_q;
  assign line_idx      = line_q[IDX_W-1:0];
  assign line_tag      = line_q[LINE_W-1:IDX_W];
  assign inv_en        = fill_req_vld && fill_req_rdy;
  assign busy          = (st_q == RF_FILL);
  assign fw_en         = busy && fill_vld;
  assign fw_sel        = beat_q;
  assign inst_en       = fw_en && (beat_q == LAST_BEAT);

  // R2: an unaccepted request keeps its line address
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_vld && !fill_req_rdy) |=> (fill_req_vld && $stable(fill_req_line)));

endmodule

// File: rtl/l1d_dual_cache.sv
module l1d_dual_cache #(
  parameter int ADDR_W = 40,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 8,
  parameter int WORD_W = 64,
  parameter int NPORT  = 2,
  localparam int BOFF_W = $clog2(WORD_W / 8),
  localparam int DW_W   = ADDR_W - BOFF_W,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [NPORT-1:0]             ld_req,
  input  logic [NPORT-1:0][DW_W-1:0]   ld_addr,
  output logic [NPORT-1:0]             ld_done,
  output logic [NPORT-1:0][WORD_W-1:0] ld_data,
  input  logic                         st_req,
  input  logic [DW_W-1:0]              st_addr,
  input  logic [WORD_W-1:0]            st_wdata,
  input  logic [WORD_W/8-1:0]          st_be,
  output logic                         st_rdy,
  output logic                         wq_vld,
  output logic [DW_W-1:0]              wq_addr,
  output logic [WORD_W-1:0]            wq_data,
  output logic [WORD_W/8-1:0]          wq_be,
  input  logic                         wq_rdy,
  output logic                         fill_req_vld,
  output logic [LINE_W-1:0]            fill_req_line,
  input  logic                         fill_req_rdy,
  input  logic                         fill_vld,
  input  logic [WORD_W-1:0]            fill_data
);

  localparam int WSEL_W = OFF_W - BOFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;

  function automatic logic [LINE_W-1:0] line_of(input logic [DW_W-1:0] dw);
    return dw[DW_W-1:WSEL_W];
  endfunction
  function automatic logic [WSEL_W-1:0] sel_of(input logic [DW_W-1:0] dw);
    return dw[WSEL_W-1:0];
  endfunction
  function automatic logic [IDX_W-1:0] idx_of(input logic [LINE_W-1:0] ln);
    return ln[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [LINE_W-1:0] ln);
    return ln[LINE_W-1:IDX_W];
  endfunction

  // lookup ports 0..NPORT-1 serve loads, port NPORT serves the store
  logic [NPORT:0][IDX_W-1:0]          lk_idx;
  logic [NPORT:0][TAG_W-1:0]          lk_tag;
  logic [NPORT:0]                     lk_hit;
  logic [NPORT-1:0][IDX_W-1:0]        rd_idx;
  logic [NPORT-1:0][WSEL_W-1:0]       rd_sel;
  logic [NPORT-1:0]                   miss_vec;
  logic [NPORT-1:0][LINE_W-1:0]       miss_line;

  logic              st_fire, st_hit;
  logic [IDX_W-1:0]  rf_idx;
  logic [TAG_W-1:0]  rf_tag;
  logic              rf_inv, rf_fw, rf_inst, rf_busy;
  logic [WSEL_W-1:0] rf_sel;

  for (genvar p = 0; p < NPORT; p++) begin : g_ld
    assign lk_idx[p]    = idx_of(line_of(ld_addr[p]));
    assign lk_tag[p]    = tag_of(line_of(ld_addr[p]));
    assign rd_idx[p]    = lk_idx[p];
    assign rd_sel[p]    = sel_of(ld_addr[p]);
    assign ld_done[p]   = ld_req[p] && lk_hit[p];
    assign miss_vec[p]  = ld_req[p] && !lk_hit[p];
    assign miss_line[p] = line_of(ld_addr[p]);
  end

  assign lk_idx[NPORT] = idx_of(line_of(st_addr));
  assign lk_tag[NPORT] = tag_of(line_of(st_addr));

  // write-through path: straight to the write queue
  assign st_rdy  = wq_rdy;
  assign wq_vld  = st_req;
  assign wq_addr = st_addr;
  assign wq_data = st_wdata;
  assign wq_be   = st_be;
  assign st_fire = st_req && wq_rdy;
  assign st_hit  = st_fire && lk_hit[NPORT];

  l1d_tag_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .NRD   (NPORT + 1)
  ) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .rd_idx    (lk_idx),
    .rd_tag    (lk_tag),
    .rd_hit    (lk_hit),
    .inv_en    (rf_inv),
    .inst_en   (rf_inst),
    .line_idx  (rf_idx),
    .line_tag  (rf_tag),
    .fill_busy (rf_busy)
  );

  l1d_line_data #(
    .IDX_W  (IDX_W),
    .WSEL_W (WSEL_W),
    .WORD_W (WORD_W),
    .NRD    (NPORT)
  ) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rd_idx),
    .rd_sel  (rd_sel),
    .rd_data (ld_data),
    .fw_en   (rf_fw),
    .fw_idx  (rf_idx),
    .fw_sel  (rf_sel),
    .fw_data (fill_data),
    .sw_en   (st_hit),
    .sw_idx  (lk_idx[NPORT]),
    .sw_sel  (sel_of(st_addr)),
    .sw_data (st_wdata),
    .sw_be   (st_be)
  );

  l1d_refill_fsm #(
    .LINE_W (LINE_W),
    .IDX_W  (IDX_W),
    .WSEL_W (WSEL_W),
    .NPORT  (NPORT)
  ) u_refill (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_vec      (miss_vec),
    .miss_line     (miss_line),
    .fill_req_rdy  (fill_req_rdy),
    .fill_vld      (fill_vld),
    .fill_req_vld  (fill_req_vld),
    .fill_req_line (fill_req_line),
    .line_idx      (rf_idx),
    .line_tag      (rf_tag),
    .inv_en        (rf_inv),
    .fw_en         (rf_fw),
    .fw_sel        (rf_sel),
    .inst_en       (rf_inst),
    .busy          (rf_busy)
  );

  // R9: a store alone, with the refill engine idle, never starts a refill
  a_r9_store_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && (ld_req == '0) && !fill_req_vld && !rf_busy) |=> !fill_req_vld);

endmodule

// File: tb/sim_l1d_dual_cache.sv
module sim_l1d_dual_cache;

  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             flush = 1'b0;
  logic [1:0]       ld_req = '0;
  logic [1:0][36:0] ld_addr = '0;
  logic [1:0]       ld_done;
  logic [1:0][63:0] ld_data;
  logic             st_req = 1'b0;
  logic [36:0]      st_addr = '0;
  logic [63:0]      st_wdata = '0;
  logic [7:0]       st_be = '0;
  logic             st_rdy;
  logic             wq_vld;
  logic [36:0]      wq_addr;
  logic [63:0]      wq_data;
  logic [7:0]       wq_be;
  logic             wq_rdy = 1'b1;
  logic             fill_req_vld;
  logic [34:0]      fill_req_line;
  logic             fill_req_rdy = 1'b0;
  logic             fill_vld = 1'b0;
  logic [63:0]      fill_data = '0;

  int errs = 0;
  int checks = 0;

  l1d_dual_cache u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ld_req(ld_req), .ld_addr(ld_addr), .ld_done(ld_done), .ld_data(ld_data),
    .st_req(st_req), .st_addr(st_addr), .st_wdata(st_wdata), .st_be(st_be),
    .st_rdy(st_rdy), .wq_vld(wq_vld), .wq_addr(wq_addr), .wq_data(wq_data),
    .wq_be(wq_be), .wq_rdy(wq_rdy), .fill_req_vld(fill_req_vld),
    .fill_req_line(fill_req_line), .fill_req_rdy(fill_req_rdy),
    .fill_vld(fill_vld), .fill_data(fill_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // doubleword address from tag, index and word select
  function automatic logic [36:0] mk(input logic [26:0] t, input logic [7:0] i, input logic [1:0] w);
    return {t, i, w};
  endfunction

  // next-level memory contents
  function automatic logic [63:0] mem_word(input logic [34:0] ln, input logic [1:0] k);
    return {ln[31:0] ^ 32'h5A5A0F0F, 24'hC0DE00, 6'd0, k};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // serve an already-visible refill request
  task automatic fill_line(input logic [34:0] ln);
    chk(fill_req_vld === 1'b1, "R2 request raised", 64'(fill_req_vld), 64'd1);
    chk(fill_req_line === ln, "R2 line address", 64'(fill_req_line), 64'(ln));
    @(negedge clk); #1;
    chk(fill_req_vld === 1'b1 && fill_req_line === ln, "R2 request held",
        64'(fill_req_line), 64'(ln));
    @(negedge clk);
    fill_req_rdy = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      fill_req_rdy = 1'b0;
      fill_vld = 1'b1;
      fill_data = mem_word(ln, 2'(k));
    end
    @(negedge clk);
    fill_vld = 1'b0;
    fill_data = '0;
    #1;
  endtask

  localparam logic [36:0] A = 37'(27'h0123 << 10) | 37'(8'h10 << 2);
  localparam logic [36:0] B = 37'(27'h0456 << 10) | 37'(8'h20 << 2);
  localparam logic [36:0] C = 37'(27'h0789 << 10) | 37'(8'h30 << 2);
  localparam logic [36:0] D = 37'(27'h00AA << 10) | 37'(8'h40 << 2);
  localparam logic [36:0] E = 37'(27'h00BB << 10) | 37'(8'h41 << 2);
  localparam logic [36:0] F = 37'(27'h00CC << 10) | 37'(8'h50 << 2);
  localparam logic [36:0] G = 37'(27'h0DDD << 10) | 37'(8'h10 << 2);

  function automatic logic [34:0] ln_of(input logic [36:0] a);
    return a[36:2];
  endfunction

  task automatic t_reset_and_miss();
    #1;
    chk(ld_done === 2'b00, "R1 no load done after reset", 64'(ld_done), 64'd0);
    chk(fill_req_vld === 1'b0, "R1 no refill request", 64'(fill_req_vld), 64'd0);
    chk(wq_vld === 1'b0, "R1 write queue idle", 64'(wq_vld), 64'd0);
    @(negedge clk);
    ld_req[0] = 1'b1; ld_addr[0] = A | 37'd1;
    #1;
    chk(ld_done[0] === 1'b0, "R1 cold cache misses", 64'(ld_done[0]), 64'd0);
    @(negedge clk); #1;
    fill_line(ln_of(A));
    chk(ld_done[0] === 1'b1, "R3 hit after install", 64'(ld_done[0]), 64'd1);
    chk(ld_data[0] === mem_word(ln_of(A), 2'd1), "R3 word 1", ld_data[0], mem_word(ln_of(A), 2'd1));
    ld_addr[0] = A | 37'd3;
    #1;
    chk(ld_data[0] === mem_word(ln_of(A), 2'd3), "R3 word 3", ld_data[0], mem_word(ln_of(A), 2'd3));
    ld_req[0] = 1'b0;
  endtask

  task automatic t_dual_hit();
    @(negedge clk);
    ld_req[1] = 1'b1; ld_addr[1] = B | 37'd2;
    #1;
    @(negedge clk); #1;
    fill_line(ln_of(B));
    ld_req[0] = 1'b1; ld_addr[0] = A;
    #1;
    chk(ld_done === 2'b11, "R4 both ports done", 64'(ld_done), 64'd3);
    chk(ld_data[0] === mem_word(ln_of(A), 2'd0), "R4 port0 data", ld_data[0], mem_word(ln_of(A), 2'd0));
    chk(ld_data[1] === mem_word(ln_of(B), 2'd2), "R4 port1 data", ld_data[1], mem_word(ln_of(B), 2'd2));
    ld_req = '0;
  endtask

  task automatic t_store_hit();
    logic [63:0] old_w, new_w;
    old_w = mem_word(ln_of(A), 2'd2);
    new_w = {old_w[63:32], 32'h55667788};
    @(negedge clk);
    st_req = 1'b1; st_addr = A | 37'd2; st_wdata = 64'h1122334455667788; st_be = 8'h0F; wq_rdy = 1'b1;
    ld_req[0] = 1'b1; ld_addr[0] = A | 37'd2;
    #1;
    chk(st_rdy === 1'b1 && wq_vld === 1'b1, "R7 store accepted", 64'({st_rdy, wq_vld}), 64'd3);
    chk(wq_addr === (A | 37'd2), "R7 queue address", 64'(wq_addr), 64'(A | 37'd2));
    chk(wq_data === 64'h1122334455667788 && wq_be === 8'h0F, "R7 queue data", wq_data, 64'h1122334455667788);
    chk(ld_done[0] === 1'b1 && ld_data[0] === old_w, "R10 pre-store data", ld_data[0], old_w);
    @(negedge clk);
    st_req = 1'b0;
    #1;
    chk(ld_data[0] === new_w, "R8 byte-masked update", ld_data[0], new_w);
    @(negedge clk);
    st_req = 1'b1; st_wdata = 64'hFFFF_FFFF_FFFF_FFFF; st_be = 8'hFF; wq_rdy = 1'b0;
    #1;
    chk(st_rdy === 1'b0, "R7 st_rdy follows wq_rdy", 64'(st_rdy), 64'd0);
    @(negedge clk);
    st_req = 1'b0; wq_rdy = 1'b1;
    #1;
    chk(ld_data[0] === new_w, "R7 unaccepted store ignored", ld_data[0], new_w);
    ld_req = '0;
  endtask

  task automatic t_store_miss();
    @(negedge clk);
    st_req = 1'b1; st_addr = C; st_wdata = 64'hDEAD_BEEF_0000_1111; st_be = 8'hFF;
    #1;
    chk(wq_vld === 1'b1 && wq_addr === C, "R9 miss written through", 64'(wq_addr), 64'(C));
    @(negedge clk);
    st_req = 1'b0;
    #1;
    chk(fill_req_vld === 1'b0, "R9 no refill on store miss", 64'(fill_req_vld), 64'd0);
    ld_req[0] = 1'b1; ld_addr[0] = C;
    #1;
    chk(ld_done[0] === 1'b0, "R9 line not allocated", 64'(ld_done[0]), 64'd0);
    @(negedge clk); #1;
    fill_line(ln_of(C));
    chk(ld_done[0] === 1'b1 && ld_data[0] === mem_word(ln_of(C), 2'd0), "R9 data from refill",
        ld_data[0], mem_word(ln_of(C), 2'd0));
    ld_req = '0;
  endtask

  task automatic t_dual_miss();
    @(negedge clk);
    ld_req = 2'b11; ld_addr[0] = D | 37'd3; ld_addr[1] = E | 37'd1;
    #1;
    chk(ld_done === 2'b00, "R5 both miss", 64'(ld_done), 64'd0);
    @(negedge clk); #1;
    chk(fill_req_line === ln_of(D), "R5 port0 requested first", 64'(fill_req_line), 64'(ln_of(D)));
    fill_line(ln_of(D));
    chk(ld_done === 2'b01, "R5 only port0 done", 64'(ld_done), 64'd1);
    chk(ld_data[0] === mem_word(ln_of(D), 2'd3), "R5 port0 data", ld_data[0], mem_word(ln_of(D), 2'd3));
    @(negedge clk);
    ld_req[0] = 1'b0;
    #1;
    chk(fill_req_vld === 1'b1 && fill_req_line === ln_of(E), "R5 port1 requested second",
        64'(fill_req_line), 64'(ln_of(E)));
    fill_line(ln_of(E));
    chk(ld_done[1] === 1'b1 && ld_data[1] === mem_word(ln_of(E), 2'd1), "R5 port1 data",
        ld_data[1], mem_word(ln_of(E), 2'd1));
    ld_req = '0;
  endtask

  task automatic t_same_line();
    @(negedge clk);
    ld_req = 2'b11; ld_addr[0] = F; ld_addr[1] = F | 37'd3;
    #1;
    @(negedge clk); #1;
    fill_line(ln_of(F));
    chk(ld_done === 2'b11, "R6 one refill answers both", 64'(ld_done), 64'd3);
    chk(ld_data[1] === mem_word(ln_of(F), 2'd3), "R6 port1 data", ld_data[1], mem_word(ln_of(F), 2'd3));
    @(negedge clk); #1;
    chk(fill_req_vld === 1'b0, "R6 no second request", 64'(fill_req_vld), 64'd0);
    ld_req = '0;
  endtask

  task automatic t_evict();
    @(negedge clk);
    ld_req[0] = 1'b1; ld_addr[0] = G;
    #1;
    @(negedge clk); #1;
    ld_req[1] = 1'b1; ld_addr[1] = A;
    #1;
    chk(ld_done[1] === 1'b1, "R12 victim valid before accept", 64'(ld_done[1]), 64'd1);
    ld_req[1] = 1'b0;
    fill_line(ln_of(G));
    chk(ld_done[0] === 1'b1, "R12 new line installed", 64'(ld_done[0]), 64'd1);
    ld_req[0] = 1'b0; ld_req[1] = 1'b1; ld_addr[1] = A;
    #1;
    chk(ld_done[1] === 1'b0, "R12 victim evicted", 64'(ld_done[1]), 64'd0);
    @(negedge clk); #1;
    fill_line(ln_of(A));
    chk(ld_done[1] === 1'b1, "R12 victim refilled", 64'(ld_done[1]), 64'd1);
    ld_req = '0;
  endtask

  task automatic t_flush();
    @(negedge clk);
    ld_req[0] = 1'b1; ld_addr[0] = B;
    #1;
    chk(ld_done[0] === 1'b1, "R11 hit before flush", 64'(ld_done[0]), 64'd1);
    @(negedge clk);
    ld_req[0] = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0; ld_req = 2'b11; ld_addr[0] = B; ld_addr[1] = D;
    #1;
    chk(ld_done === 2'b00, "R11 all lines invalid", 64'(ld_done), 64'd0);
    ld_req[1] = 1'b0;
    @(negedge clk); #1;
    fill_line(ln_of(B));
    chk(ld_done[0] === 1'b1, "R11 refill after flush", 64'(ld_done[0]), 64'd1);
    ld_req = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_and_miss();
    t_dual_hit();
    t_store_hit();
    t_store_miss();
    t_dual_miss();
    t_same_line();
    t_evict();
    t_flush();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule